// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Sequencer

This block is a synchronous controller for the asynchronous control pins of a 16-bit pseudo-static RAM. It drives the active-low chip enable, the power-down enable, output enable, write enable, byte enables, a 21-bit address and a 16-bit data bus. A host starts one of three operations through a small command port.

The first operation writes the power-down configuration. It uses a fixed key sequence of six bus cycles and then waits out a recovery time. The second operation enters power-down. The third leaves power-down. Its hold-off before the chip may be enabled again depends on the retention mode that was last programmed. Every minimum time is a parameter in clock cycles, and one shared down-counter times them all. After reset the block runs the full power-up hold-off and then reports done.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset, and right after it, the outputs are in their idle state: mem_e1_n=1, mem_e2=1, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, busy=1 and done=0. Once reset is released, the block holds chip enable high for DEEP_EXIT_CYC clocks. It then pulses done, and busy goes low.
- R2: cmd_op selects the operation: 2'b01 programs the configuration, 2'b10 enters power-down and 2'b11 exits power-down. A command is taken only on a clock where cmd_valid=1 and busy=0. A command presented while busy is high has no effect.
- R3: Programming issues exactly six bus cycles, with mem_e2=1 and mem_be_n=2'b00 throughout. Cycles 1, 2, 3 and 6 are reads. Cycle 4 writes 0x0000 and cycle 5 writes the captured cmd_data. Every cycle uses address 0x1FFFFF except cycle 5, which uses the captured cmd_addr.
- R4: In each bus cycle, chip enable is low for SETUP_CYC clocks before the strobe falls. The strobe then stays low for STROBE_CYC clocks. mem_dq_oe is 1 only in write cycles.
- R5: Output enable and write enable are never low together. Neither one is low while chip enable is high.
- R6: After cycle 6, chip enable stays high for RECOV_CYC clocks before done. From acceptance, done appears on clock 6*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+RECOV_CYC+1.
- R7: Power-down entry drives mem_e2 low while mem_e1_n stays high. Done appears PD_SETUP_CYC+PD_HOLD_CYC+1 clocks after acceptance. mem_e2 then stays low until an exit command.
- R8: On exit, mem_e2 goes high and chip enable is held high for a wait that depends on the retention mode. The mode is bits [1:0] of the last programmed data: 2'b00 means deep power-down. The wait is DEEP_EXIT_CYC clocks in deep mode and PART_EXIT_CYC clocks otherwise, and deep is assumed until the first programming. Done appears one clock after the wait.
- R9: A command that does not fit the power state is ignored, with no done and no pin change. That covers exit while active, and entry or programming while powered down.
- R10: done is high for exactly one clock, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | 21 | Configuration address for programming |
| cmd_data | input | 16 | Configuration data for programming |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| mem_e1_n | output | 1 | Chip enable, active low |
| mem_e2 | output | 1 | Power-down enable, low selects power-down |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_addr | output | 21 | Memory address |
| mem_dq | output | 16 | Write data |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume the host honours the handshake. They also assume the timing parameters are at least one and PART_EXIT_CYC does not exceed DEEP_EXIT_CYC, so the minimum high time checked before each chip enable fall is the shorter exit wait. The bench waits for busy to drop before every legal command and drives inputs only on falling edges. It deliberately sends commands while busy, and in the wrong power state, to show they have no effect. Random addresses and data, including random retention-mode fields, steer the choice of exit wait.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int AW            = 21,
  parameter int DW            = 16,
  parameter int SETUP_CYC     = 1,
  parameter int STROBE_CYC    = 3,
  parameter int HOLD_CYC      = 3,
  parameter int RECOV_CYC     = 20,
  parameter int PD_SETUP_CYC  = 3,
  parameter int PD_HOLD_CYC   = 22,
  parameter int DEEP_EXIT_CYC = 75000,
  parameter int PART_EXIT_CYC = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          done,
  output logic          mem_e1_n,
  output logic          mem_e2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [1:0]    mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq,
  output logic          mem_dq_oe
);
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = mx(mx(mx(SETUP_CYC, STROBE_CYC), mx(HOLD_CYC, RECOV_CYC)),
                           mx(mx(PD_SETUP_CYC, PD_HOLD_CYC), mx(DEEP_EXIT_CYC, PART_EXIT_CYC)));
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] L_SET  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_STB  = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] L_HLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_REC  = CW'(RECOV_CYC - 1);
  localparam logic [CW-1:0] L_PDS  = CW'(PD_SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PDH  = CW'(PD_HOLD_CYC - 1);
  localparam logic [CW-1:0] L_DEEP = CW'(DEEP_EXIT_CYC - 1);
  localparam logic [CW-1:0] L_PART = CW'(PART_EXIT_CYC - 1);

  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ENTER = 2'b10;
  localparam logic [1:0] OP_EXIT  = 2'b11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE, ST_SET, ST_STB, ST_HLD, ST_REC, ST_PDS, ST_PDH, ST_PD
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [AW-1:0] cfg_a;
  logic [DW-1:0] cfg_d;
  logic          deep_q;
  logic          done_q;

  wire last   = (cnt == '0);
  wire wr_cyc = (idx == 3'd3) || (idx == 3'd4);
  wire on_bus = (st == ST_SET) || (st == ST_STB) || (st == ST_HLD);
  wire strobe = (st == ST_STB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_WAKE;
      cnt    <= L_DEEP;
      idx    <= '0;
      cfg_a  <= '0;
      cfg_d  <= '0;
      deep_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          if (cmd_op == OP_PROG) begin
            st    <= ST_SET;
            cnt   <= L_SET;
            idx   <= '0;
            cfg_a <= cmd_addr;
            cfg_d <= cmd_data;
          end else if (cmd_op == OP_ENTER) begin
            st  <= ST_PDS;
            cnt <= L_PDS;
          end
        end
        ST_PD: if (cmd_valid && cmd_op == OP_EXIT) begin
          st  <= ST_WAKE;
          cnt <= deep_q ? L_DEEP : L_PART;
        end
        ST_WAKE, ST_REC: if (last) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_SET: if (last) begin
          st  <= ST_STB;
          cnt <= L_STB;
        end
        ST_STB: if (last) begin
          st  <= ST_HLD;
          cnt <= L_HLD;
        end
        ST_HLD: if (last) begin
          if (idx == 3'd5) begin
            st     <= ST_REC;
            cnt    <= L_REC;
            deep_q <= (cfg_d[1:0] == 2'b00);
          end else begin
            st  <= ST_SET;
            cnt <= L_SET;
            idx <= idx + 3'd1;
          end
        end
        ST_PDS: if (last) begin
          st  <= ST_PDH;
          cnt <= L_PDH;
        end
        ST_PDH: if (last) begin
          st     <= ST_PD;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = !((st == ST_IDLE) || (st == ST_PD));
  assign done      = done_q;
  assign mem_e1_n  = !((st == ST_SET) || strobe);
  assign mem_e2    = !((st == ST_PDS) || (st == ST_PDH) || (st == ST_PD));
  assign mem_oe_n  = !(strobe && !wr_cyc);
  assign mem_we_n  = !(strobe && wr_cyc);
  assign mem_be_n  = on_bus ? 2'b00 : 2'b11;
  assign mem_addr  = (on_bus && idx == 3'd4) ? cfg_a : {AW{1'b1}};
  assign mem_dq    = (idx == 3'd4) ? cfg_d : '0;
  assign mem_dq_oe = on_bus && wr_cyc;
endmodule

module psram_pwr_seq_chk #(
  parameter int AW            = 21,
  parameter int PD_MIN_CYC    = 25,
  parameter int PART_EXIT_CYC = 250
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_e1_n,
  input logic          mem_e2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);
  int lo_cnt;
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      if (mem_e2) lo_cnt <= 0;
      else if (lo_cnt < PD_MIN_CYC) lo_cnt <= lo_cnt + 1;
      if (!mem_e2) hi_cnt <= 0;
      else if (hi_cnt < PART_EXIT_CYC) hi_cnt <= hi_cnt + 1;
    end
  end

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n || mem_we_n));
  a_r5_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_e1_n);
  a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  a_r4_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  a_r4_addr_stable_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  a_r7_pd_enable_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_e2 |-> mem_e1_n);
  a_r7_pd_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_e2) |-> (lo_cnt >= PD_MIN_CYC));
  a_r8_exit_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_e1_n) |-> (hi_cnt >= PART_EXIT_CYC));
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .AW(AW), .PD_MIN_CYC(PD_SETUP_CYC + PD_HOLD_CYC), .PART_EXIT_CYC(PART_EXIT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_e1_n(mem_e1_n),
  .mem_e2(mem_e2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb_top;
  localparam int SU = 2, SB = 3, HO = 2, RC = 5, PS = 3, PH = 22, DP = 600, PT = 40;
  localparam int PROG_LAT  = 6 * (SU + SB + HO) + RC + 1;
  localparam int ENTER_LAT = PS + PH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [20:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic busy, done, mem_e1_n, mem_e2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_be_n;
  logic [20:0] mem_addr;
  logic [15:0] mem_dq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .SETUP_CYC(SU), .STROBE_CYC(SB), .HOLD_CYC(HO), .RECOV_CYC(RC),
    .PD_SETUP_CYC(PS), .PD_HOLD_CYC(PH), .DEEP_EXIT_CYC(DP), .PART_EXIT_CYC(PT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
    .mem_e1_n(mem_e1_n), .mem_e2(mem_e2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  int ncyc = 0;
  int e1run = 0;
  int slen = 0;
  logic prev_str = 1'b0;
  logic t_we [16];
  int t_addr [16], t_data [16], t_dqoe [16], t_be [16], t_e2 [16], t_setup [16], t_len [16];

  always @(negedge clk) begin
    if (rst_n) begin
      logic str;
      str = !mem_oe_n || !mem_we_n;
      if (!mem_e1_n) e1run = e1run + 1; else e1run = 0;
      if (str && !prev_str) begin
        t_we[ncyc%16]    = !mem_we_n;
        t_addr[ncyc%16]  = int'(mem_addr);
        t_data[ncyc%16]  = int'(mem_dq);
        t_dqoe[ncyc%16]  = int'(mem_dq_oe);
        t_be[ncyc%16]    = int'(mem_be_n);
        t_e2[ncyc%16]    = int'(mem_e2);
        t_setup[ncyc%16] = e1run - 1;
        slen = 0;
        ncyc = ncyc + 1;
      end
      if (str) slen = slen + 1;
      if (!str && prev_str) t_len[(ncyc-1)%16] = slen;
      prev_str = str;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [20:0] a, input logic [15:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic wait_done(input int start, input int limit, output int lat);
    lat = start;
    while (!done && lat < limit) begin @(negedge clk); lat++; end
    if (!done) lat = -1;
    chk(!busy, "R10", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R10", "done one clock", int'(done), 0);
  endtask

  function automatic int exp_addr(input int i, input int a);
    return (i == 4) ? a : 21'h1FFFFF;
  endfunction

  function automatic int exit_lat(input logic [15:0] d);
    return ((d[1:0] == 2'b00) ? DP : PT) + 1;
  endfunction

  task automatic check_trace(input int base, input logic [20:0] a, input logic [15:0] d);
    chk(ncyc - base == 6, "R3", "bus cycle count", ncyc - base, 6);
    for (int i = 0; i < 6; i++) begin
      int k;
      bit w;
      k = (base + i) % 16;
      w = (i == 3) || (i == 4);
      chk(t_we[k] == w, "R3", "cycle kind", int'(t_we[k]), int'(w));
      chk(t_addr[k] == exp_addr(i, int'(a)), "R3", "cycle address", t_addr[k], exp_addr(i, int'(a)));
      chk(t_be[k] == 0 && t_e2[k] == 1, "R3", "byte enables and e2", t_be[k] * 2 + t_e2[k], 1);
      chk(t_dqoe[k] == int'(w), "R4", "data drive", t_dqoe[k], int'(w));
      if (w) chk(t_data[k] == ((i == 3) ? 0 : int'(d)), "R3", "write data", t_data[k], (i == 3) ? 0 : int'(d));
      chk(t_setup[k] == SU, "R4", "enable setup", t_setup[k], SU);
      chk(t_len[k] == SB, "R4", "strobe length", t_len[k], SB);
    end
  endtask

  task automatic do_prog(input logic [20:0] a, input logic [15:0] d);
    int base, lat;
    while (busy) @(negedge clk);
    base = ncyc;
    issue(2'b01, a, d);
    wait_done(1, 400, lat);
    chk(lat == PROG_LAT, "R6", "program latency", lat, PROG_LAT);
    check_trace(base, a, d);
  endtask

  task automatic do_enter();
    int lat;
    issue(2'b10, '0, '0);
    chk(!mem_e2 && mem_e1_n, "R7", "e2 low with e1 high", int'(mem_e2), 0);
    wait_done(1, 400, lat);
    chk(lat == ENTER_LAT, "R7", "entry latency", lat, ENTER_LAT);
    chk(!mem_e2 && !busy, "R7", "stays powered down", int'(mem_e2), 0);
  endtask

  task automatic do_exit(input int exp);
    int lat;
    issue(2'b11, '0, '0);
    chk(mem_e2 && mem_e1_n, "R8", "e2 high with e1 high", int'(mem_e2), 1);
    wait_done(1, 2000, lat);
    chk(lat == exp, "R8", "exit latency", lat, exp);
  endtask

  task automatic ignored(input logic [1:0] op, input bit e2_exp, input string req);
    int base;
    bit saw;
    base = ncyc;
    saw = 1'b0;
    issue(op, 21'h0ABCD, 16'h1234);
    repeat (60) begin
      if (done || busy) saw = 1'b1;
      @(negedge clk);
    end
    chk(!saw, req, "no activity after ignored command", int'(saw), 0);
    chk(mem_e2 == e2_exp, req, "power state unchanged", int'(mem_e2), int'(e2_exp));
    chk(ncyc == base, req, "no bus cycles", ncyc - base, 0);
  endtask

  initial begin
    int n, lat, base;
    logic [20:0] ra;
    logic [15:0] rd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(mem_e1_n && mem_e2 && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "idle pins in reset",
        int'({mem_e1_n, mem_e2, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b11110);
    chk(busy && !done, "R1", "busy in reset", int'({busy, done}), 2);
    rst_n = 1'b1;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(n == DP, "R1", "power-up wait", n, DP);
    chk(!busy && mem_e1_n, "R1", "ready after wake", int'(busy), 0);
    @(negedge clk);

    ignored(2'b11, 1'b1, "R9");
    do_prog(21'h12345, 16'h5A30);
    do_enter();
    ignored(2'b10, 1'b0, "R9");
    ignored(2'b01, 1'b0, "R9");
    do_exit(DP + 1);

    do_prog(21'h00001, 16'hC3A1);
    do_enter();
    do_exit(PT + 1);

    base = ncyc;
    issue(2'b01, 21'h1F0F0, 16'h0002);
    repeat (9) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    wait_done(11, 400, lat);
    chk(lat == PROG_LAT, "R2", "program unaffected by busy command", lat, PROG_LAT);
    check_trace(base, 21'h1F0F0, 16'h0002);
    repeat (40) @(negedge clk);
    chk(mem_e2 && !busy && !done, "R2", "command during busy ignored", int'(mem_e2), 1);

    for (int it = 0; it < 12; it++) begin
      ra = 21'($urandom);
      rd = 16'($urandom);
      if (it % 3 == 0) rd[1:0] = 2'b00;
      do_prog(ra, rd);
      if ($urandom % 2 == 1 || it % 3 == 0) begin
        do_enter();
        do_exit(exit_lat(rd));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule